// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns a core clock into a one-cycle enable strobe at a reduced rate, so that a downstream synchronous transfer engine can run slower than the core clock without a second clock net. A 3-bit conversion code selects one of five rates: the core rate itself, two thirds of it, one half, one third, and one quarter. The fractional setting gives two strobes in every three core cycles, on the first and third cycle of each window.

The code map is fixed and not monotonic. Two different codes both select the one-third rate. Two codes are reserved; while either of them is in force, the strobe is held off and a flag is raised. A new code is accepted only at the start of a divide period, so a period is never cut short or stretched. A separate combinational output tells whether a given core-clock frequency, expressed in 10 kHz steps, lies inside the band intended for the code in force.

Top module: `fracdiv_strobe`

## Requirements
- R1: Codes 000 and 100 give a strobe on cycles 0, 3, 6, ... of the period count. Code 011 gives a strobe on every second cycle. Code 101 gives a strobe on every fourth cycle.
- R2: Code 001 asserts the strobe on every core cycle.
- R3: Code 010 gives a 3-cycle window with the strobe on phases 0 and 2 and off on phase 1, so there are exactly two strobes per three cycles.
- R4: Codes 110 and 111 hold the strobe low and assert `bad_code` for as long as they are in force. A legal code presented at a period boundary clears the flag and produces a strobe in that same cycle.
- R5: A code change made in the middle of a period has no effect on `tick` or `bad_code` until that period has run its full length. The new code governs from the first cycle of the next period.
- R6: A synchronous reset clears the phase. With a legal code applied, the strobe is high on the first cycle after reset is released.
- R7: `freq_ok` is high when `freq_in` (in units of 10 kHz) lies inside the inclusive band for the code in force, and low otherwise. The bands are: 1667..2500 for 001, 2501..3750 for 010, 3751..5000 for 011, 5001..7500 for 000 and 100, and 7501..8000 for 101. `freq_ok` is always low for a reserved code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| code | input | 3 | Conversion-factor code |
| freq_in | input | FW | Core-clock frequency in 10 kHz units |
| tick | output | 1 | One-cycle enable strobe at the divided rate |
| bad_code | output | 1 | The code in force is reserved |
| freq_ok | output | 1 | `freq_in` lies in the band for the code in force |

## Verification
The bench builds the block with the default `FW` of 14. This width makes a full sweep of every `freq_in` value under every one of the eight codes practical, so each band edge and each value just outside it is compared. For every legal code, the strobe pattern is checked cycle by cycle over several whole periods, starting from reset. Mid-period switches are also applied, one to a faster code and one to a reserved code, to show where the new code first takes hold.

// File: rtl/fracdiv_strobe.sv
module fracdiv_strobe #(
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    code,
  input  logic [FW-1:0] freq_in,
  output logic          tick,
  output logic          bad_code,
  output logic          freq_ok
);

  logic [1:0]  ph;
  logic [2:0]  held;
  logic [2:0]  eff;
  logic [1:0]  last;
  logic [31:0] lo;
  logic [31:0] hi;
  logic [31:0] fval;

  assign eff      = (ph == 2'd0) ? code : held;
  assign bad_code = eff[2] & eff[1];
  assign fval     = 32'(freq_in);

  always_comb begin
    case (eff)
      3'b001:                 last = 2'd0;
      3'b011:                 last = 2'd1;
      3'b000, 3'b100, 3'b010: last = 2'd2;
      3'b101:                 last = 2'd3;
      default:                last = 2'd0;
    endcase
  end

  always_comb begin
    case (eff)
      3'b010:  tick = (ph != 2'd1);
      default: tick = !bad_code && (ph == 2'd0);
    endcase
  end

  always_comb begin
    case (eff)
      3'b001:         begin lo = 32'd1667; hi = 32'd2500; end
      3'b010:         begin lo = 32'd2501; hi = 32'd3750; end
      3'b011:         begin lo = 32'd3751; hi = 32'd5000; end
      3'b000, 3'b100: begin lo = 32'd5001; hi = 32'd7500; end
      3'b101:         begin lo = 32'd7501; hi = 32'd8000; end
      default:        begin lo = 32'd1;    hi = 32'd0;    end
    endcase
  end

  assign freq_ok = !bad_code && (fval >= lo) && (fval <= hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= 2'd0;
      held <= 3'b000;
    end else begin
      held <= eff;
      ph   <= (ph == last) ? 2'd0 : ph + 2'd1;
    end
  end

endmodule

module fracdiv_strobe_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       bad_code,
  input logic       freq_ok,
  input logic [1:0] ph,
  input logic [2:0] eff
);

  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (rst)
    bad_code |-> (!tick && !freq_ok)); // R4

  AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (rst)
    (eff == 3'b001) |-> tick); // R2

  AST_MID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ph != 2'd0 && !$past(rst)) |-> (eff == $past(eff))); // R5

  AST_FIRST_TICK: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !bad_code) |-> tick); // R6

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (rst)
    (eff == 3'b011) |-> (ph <= 2'd1)); // R1

  AST_THIRDS_REFILL: assert property (@(posedge clk) disable iff (rst)
    (eff == 3'b010 && !tick) |=> tick); // R3

endmodule

bind fracdiv_strobe fracdiv_strobe_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .bad_code(bad_code),
  .freq_ok(freq_ok), .ph(ph), .eff(eff)
);

// File: tb/fracdiv_strobe_test.sv
module fracdiv_strobe_test;
  localparam int FW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    code = 3'b001;
  logic [FW-1:0] freq_in = '0;
  logic          tick, bad_code, freq_ok;
  int            checks = 0;
  int            failures = 0;
  bit            done = 1'b0;

  fracdiv_strobe #(.FW(FW)) uut (
    .clk(clk), .rst(rst), .code(code), .freq_in(freq_in),
    .tick(tick), .bad_code(bad_code), .freq_ok(freq_ok)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_tick(input int c, input int k);
    case (c)
      1:       return 1;
      2:       return (k % 3 != 1) ? 1 : 0;
      3:       return (k % 2 == 0) ? 1 : 0;
      5:       return (k % 4 == 0) ? 1 : 0;
      0, 4:    return (k % 3 == 0) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_band(input int c, input int f);
    int lo, hi;
    case (c)
      1:       begin lo = 1667; hi = 2500; end
      2:       begin lo = 2501; hi = 3750; end
      3:       begin lo = 3751; hi = 5000; end
      0, 4:    begin lo = 5001; hi = 7500; end
      5:       begin lo = 7501; hi = 8000; end
      default: begin lo = 1;    hi = 0;    end
    endcase
    return (f >= lo && f <= hi) ? 1 : 0;
  endfunction

  task automatic restart(input int c);
    @(negedge clk);
    rst  = 1'b1;
    code = 3'(c);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R6", "reset tick", int'(tick), 1);
    chk("R4", "reset bad_code", int'(bad_code), 0);

    // R7 and R4: full sweep of freq_in under every code, phase held at zero by reset
    for (int c = 0; c < 8; c++) begin
      code = 3'(c);
      #1;
      chk("R4", "bad_code per code", int'(bad_code), (c >= 6) ? 1 : 0);
      for (int f = 0; f < (1 << FW); f++) begin
        freq_in = FW'(f);
        #1;
        if (freq_ok !== 1'(exp_band(c, f)))
          chk("R7", $sformatf("freq_ok code=%0d f=%0d", c, f), int'(freq_ok), exp_band(c, f));
        else checks++;
      end
    end

    // R1 R2 R3 R6: pattern from reset for every legal code
    for (int c = 0; c < 6; c++) begin
      restart(c);
      for (int k = 0; k < 12; k++) begin
        #5;
        chk((c == 1) ? "R2" : (c == 2) ? "R3" : "R1",
            $sformatf("tick code=%0d k=%0d", c, k), int'(tick), exp_tick(c, k));
        chk("R6", "bad_code legal", int'(bad_code), 0);
        @(negedge clk);
      end
    end

    // R4: reserved codes, then recovery on the same cycle
    for (int c = 6; c < 8; c++) begin
      restart(c);
      for (int k = 0; k < 5; k++) begin
        #5;
        chk("R4", "reserved tick", int'(tick), 0);
        chk("R4", "reserved flag", int'(bad_code), 1);
        @(negedge clk);
      end
      code = 3'b011;
      #5;
      chk("R4", "recovery tick", int'(tick), 1);
      chk("R4", "recovery flag", int'(bad_code), 0);
    end

    // R5: mid-period switch from quarter rate to half rate, then to reserved
    restart(5);
    #5;
    chk("R5", "k0 tick", int'(tick), 1);
    @(negedge clk);
    code = 3'b011;
    for (int k = 1; k < 7; k++) begin
      #5;
      chk("R5", $sformatf("switch k=%0d", k), int'(tick), (k == 4 || k == 6) ? 1 : 0);
      @(negedge clk);
    end
    code = 3'b110;
    #5;
    chk("R5", "k7 tick", int'(tick), 0);
    chk("R5", "k7 flag ignored", int'(bad_code), 0);
    @(negedge clk);
    #5;
    chk("R5", "k8 flag", int'(bad_code), 1);
    chk("R5", "k8 tick", int'(tick), 0);
    @(negedge clk);
    #5;
    chk("R4", "k9 flag held", int'(bad_code), 1);

    finish_run();
  end
endmodule